// File: doc/BRIEF.md
# CAN FD Bit Timing Parameter Solver

This block works out bit timing settings for a flexible data-rate CAN controller, once for the arbitration (nominal) phase and once for the fast data phase. Software or a configuration sequencer presents the controller clock frequency. For each phase it also presents a target bitrate, the number of time quanta per bit, the wanted sample point in tenths of a percent and a requested resynchronisation jump width. A single-cycle `start` pulse then launches the solve.

For each phase the solver finds the prescaler rounded to the nearest integer. It also finds the bitrate that prescaler really gives and the signed deviation from the target in hundredths of a percent. Finally it finds the two segments on either side of the sample point and a jump width limited by the segment after the sample point. All arithmetic runs through one shared restoring divider that yields one quotient bit per clock, so no floating point and no wide combinational divider are needed. The nominal phase is solved first and then the data phase. A one-cycle `done` marks the point where both result sets are valid. They stay on the outputs until the next solve overwrites them.

There is no streaming data path: the configuration is latched at `start` and the results are held levels, so plain control pins are used and no back-pressure applies. While `busy` is high a new `start` is ignored.

Top module: `can_fd_timing_solver`

## Requirements
- R1: The prescaler equals clock / (target bitrate × TQ per bit), rounded to the nearest integer with halves rounded up, not truncated.
- R2: A rounded prescaler of 0 is replaced by 1, and one above 1023 is replaced by 1023. In both cases the phase's unreachable flag is 1; otherwise it is 0.
- R3: The achieved bitrate equals clock / (prescaler × TQ per bit), rounded to the nearest integer.
- R4: The error output is (achieved − target) × 10000 / target, signed two's complement in units of 0.01 %. The magnitude is rounded to the nearest integer and then the sign is applied.
- R5: The sample position is (sample point in per-mille × TQ + 500) / 1000, truncated. TSEG1 is that position minus 1, the sync quantum. TSEG2 is TQ minus the position, so 1 + TSEG1 + TSEG2 equals TQ.
- R6: The sample position is held within 2 to TQ−1, so TSEG1 and TSEG2 are each at least 1 (TQ of 3 or more is assumed).
- R7: The reported jump width is the smaller of the requested width and TSEG2.
- R8: The nominal and data result sets are each computed from their own inputs. `done` is high for exactly one cycle after both are written, and `busy` is low again in that cycle.
- R9: A `start` while `busy` is high is ignored: the running solve completes with the configuration latched at its own start.
- R10: After reset `busy` and `done` are 0 and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to solve both phases |
| clk_hz | input | 32 | Controller clock frequency in Hz |
| nom_rate_target | input | 32 | Nominal phase target bitrate in bit/s |
| nom_tq_total | input | 8 | Nominal phase time quanta per bit |
| nom_sp_permille | input | 10 | Nominal sample point in 0.1 % |
| nom_sjw_req | input | 8 | Nominal requested jump width in TQ |
| dat_rate_target | input | 32 | Data phase target bitrate in bit/s |
| dat_tq_total | input | 8 | Data phase time quanta per bit |
| dat_sp_permille | input | 10 | Data sample point in 0.1 % |
| dat_sjw_req | input | 8 | Data requested jump width in TQ |
| busy | output | 1 | Solve in progress |
| done | output | 1 | One-cycle pulse, both phases solved |
| nom_presc | output | 10 | Nominal prescaler |
| nom_rate_actual | output | 32 | Nominal achieved bitrate |
| nom_err_bp | output | 32 | Nominal signed error in 0.01 % |
| nom_tseg1 | output | 8 | Nominal segment before the sample point, excluding sync |
| nom_tseg2 | output | 8 | Nominal segment after the sample point |
| nom_sjw | output | 8 | Nominal clamped jump width |
| nom_unreach | output | 1 | Nominal prescaler was forced into range |
| dat_presc | output | 10 | Data prescaler |
| dat_rate_actual | output | 32 | Data achieved bitrate |
| dat_err_bp | output | 32 | Data signed error in 0.01 % |
| dat_tseg1 | output | 8 | Data segment before the sample point, excluding sync |
| dat_tseg2 | output | 8 | Data segment after the sample point |
| dat_sjw | output | 8 | Data clamped jump width |
| dat_unreach | output | 1 | Data prescaler was forced into range |

## Verification
The bench uses a 300 kbit/s request on 16 quanta at 80 MHz. Its exact prescaler is 16.67, so a truncating divider reports 16 instead of 17 and a wrong achieved rate and error. It also drives cases where the achieved rate lands above and below the target, to catch a sign error or one-sided rounding in the error. A data request faster than the clock allows, and a very slow request, probe the prescaler floor and ceiling and the unreachable flag. Sample points of 100 % and 0 % probe the segment clamp, where a missing clamp would yield a zero-length segment and a jump width larger than TSEG2. A second `start` with changed inputs mid-solve shows whether the configuration leaks into a running calculation.

// File: rtl/can_fd_timing_pkg.sv
package can_fd_timing_pkg;
  localparam int CLK_W    = 32;
  localparam int RATE_W   = 32;
  localparam int TQ_W     = 8;
  localparam int SP_W     = 10;
  localparam int PRESC_W  = 10;
  localparam int ERR_W    = 32;
  localparam int DIV_W    = 48;
  localparam int PERMILLE = 1000;
  localparam int ERR_SCALE = 10000;

  localparam logic [DIV_W-1:0] PRESC_MAX = DIV_W'({PRESC_W{1'b1}});
  localparam logic [DIV_W-1:0] RATE_MAX  = DIV_W'({RATE_W{1'b1}});
  localparam logic [DIV_W-1:0] ERR_MAX   = DIV_W'({(ERR_W-1){1'b1}});

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT} solve_state_t;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic [TQ_W-1:0]   tq;
    logic [SP_W-1:0]   sp;
    logic [TQ_W-1:0]   sjw;
  } phase_cfg_t;

  typedef struct packed {
    logic [PRESC_W-1:0]      presc;
    logic [RATE_W-1:0]       rate;
    logic signed [ERR_W-1:0] err;
    logic [TQ_W-1:0]         tseg1;
    logic [TQ_W-1:0]         tseg2;
    logic [TQ_W-1:0]         sjw;
    logic                    unreach;
  } phase_res_t;
endpackage

// File: rtl/tq_restoring_div.sv
module tq_restoring_div #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         valid,
  output logic [W-1:0] quotient
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W:0]       rem_q;
  logic [W-1:0]     quo_q, dvs_q, dvd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, valid_q;
  logic [W:0]       trial;
  logic             fits;

  // shift next dividend bit into the partial remainder, then try the subtract
  assign trial = {rem_q[W-1:0], quo_q[W-1]};
  assign fits  = trial >= {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      dvd_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= dividend;
        dvd_q <= dividend;
        dvs_q <= divisor;
        cnt_q <= CNT_W'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? (trial - {1'b0, dvs_q}) : trial;
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q   <= 1'b0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign valid    = valid_q;
  assign quotient = quo_q;

  // quotient must be the floor of dividend / divisor for a nonzero divisor
  logic [2*W-1:0] chk_prod, chk_dvd, chk_dvs;
  assign chk_prod = {{W{1'b0}}, quo_q} * {{W{1'b0}}, dvs_q};
  assign chk_dvd  = {{W{1'b0}}, dvd_q};
  assign chk_dvs  = {{W{1'b0}}, dvs_q};

  assert_div_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && dvs_q != '0) |-> (chk_prod <= chk_dvd && (chk_dvd - chk_prod) < chk_dvs));
endmodule

// File: rtl/tq_segment_split.sv
module tq_segment_split
  import can_fd_timing_pkg::*;
(
  input  logic [TQ_W-1:0] tq,
  input  logic [TQ_W:0]   pos_raw,
  input  logic [TQ_W-1:0] sjw_req,
  output logic [TQ_W-1:0] tseg1,
  output logic [TQ_W-1:0] tseg2,
  output logic [TQ_W-1:0] sjw
);
  logic [TQ_W:0] pos_hi, pos;

  always_comb begin
    pos_hi = {1'b0, tq} - 1'b1;
    if (pos_raw < (TQ_W+1)'(2))  pos = (TQ_W+1)'(2);
    else if (pos_raw > pos_hi)   pos = pos_hi;
    else                         pos = pos_raw;
    tseg1 = TQ_W'(pos - 1'b1);
    tseg2 = TQ_W'({1'b0, tq} - pos);
    sjw   = (sjw_req > tseg2) ? tseg2 : sjw_req;
  end

  always_comb begin
    if (tq >= TQ_W'(3)) begin
      assert_seg_floor_R6: assert (tseg1 != '0 && tseg2 != '0);
    end
  end
endmodule

// File: rtl/can_fd_timing_solver.sv
module can_fd_timing_solver
  import can_fd_timing_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [CLK_W-1:0]        clk_hz,
  input  logic [RATE_W-1:0]       nom_rate_target,
  input  logic [TQ_W-1:0]         nom_tq_total,
  input  logic [SP_W-1:0]         nom_sp_permille,
  input  logic [TQ_W-1:0]         nom_sjw_req,
  input  logic [RATE_W-1:0]       dat_rate_target,
  input  logic [TQ_W-1:0]         dat_tq_total,
  input  logic [SP_W-1:0]         dat_sp_permille,
  input  logic [TQ_W-1:0]         dat_sjw_req,
  output logic                    busy,
  output logic                    done,
  output logic [PRESC_W-1:0]      nom_presc,
  output logic [RATE_W-1:0]       nom_rate_actual,
  output logic signed [ERR_W-1:0] nom_err_bp,
  output logic [TQ_W-1:0]         nom_tseg1,
  output logic [TQ_W-1:0]         nom_tseg2,
  output logic [TQ_W-1:0]         nom_sjw,
  output logic                    nom_unreach,
  output logic [PRESC_W-1:0]      dat_presc,
  output logic [RATE_W-1:0]       dat_rate_actual,
  output logic signed [ERR_W-1:0] dat_err_bp,
  output logic [TQ_W-1:0]         dat_tseg1,
  output logic [TQ_W-1:0]         dat_tseg2,
  output logic [TQ_W-1:0]         dat_sjw,
  output logic                    dat_unreach
);
  localparam int NPH = 2;

  solve_state_t            state_q;
  logic [1:0]              step_q;
  logic                    ph_q;
  logic                    done_q;
  logic [CLK_W-1:0]        clk_q;
  phase_cfg_t              cfg_q [NPH];
  phase_res_t              res_q [NPH];
  phase_cfg_t              cur;

  logic [PRESC_W-1:0]      presc_w;
  logic [RATE_W-1:0]       rate_w;
  logic signed [ERR_W-1:0] err_w;
  logic                    unr_w;

  logic                    div_start, div_valid;
  logic [DIV_W-1:0]        div_dvd, div_dvs, div_q;
  logic [DIV_W-1:0]        prod_bit, prod_presc;
  logic                    err_neg;
  logic [RATE_W-1:0]       err_diff;
  logic [ERR_W-1:0]        err_mag;
  logic [TQ_W-1:0]         seg_t1, seg_t2, seg_sjw;

  assign cur       = cfg_q[ph_q];
  assign div_start = (state_q == S_LAUNCH);

  // operand selection for the four divisions of one phase
  always_comb begin
    prod_bit   = DIV_W'(cur.rate) * DIV_W'(cur.tq);
    prod_presc = DIV_W'(presc_w) * DIV_W'(cur.tq);
    err_neg    = rate_w < cur.rate;
    err_diff   = err_neg ? (cur.rate - rate_w) : (rate_w - cur.rate);
    unique case (step_q)
      2'd0: begin
        div_dvd = DIV_W'(clk_q) + (prod_bit >> 1);
        div_dvs = prod_bit;
      end
      2'd1: begin
        div_dvd = DIV_W'(clk_q) + (prod_presc >> 1);
        div_dvs = prod_presc;
      end
      2'd2: begin
        div_dvd = DIV_W'(err_diff) * DIV_W'(ERR_SCALE) + (DIV_W'(cur.rate) >> 1);
        div_dvs = DIV_W'(cur.rate);
      end
      default: begin
        div_dvd = DIV_W'(cur.sp) * DIV_W'(cur.tq) + DIV_W'(PERMILLE / 2);
        div_dvs = DIV_W'(PERMILLE);
      end
    endcase
    err_mag = (div_q > ERR_MAX) ? ERR_W'(ERR_MAX) : div_q[ERR_W-1:0];
  end

  tq_restoring_div #(.W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .valid    (div_valid),
    .quotient (div_q)
  );

  tq_segment_split u_seg (
    .tq      (cur.tq),
    .pos_raw (div_q[TQ_W:0]),
    .sjw_req (cur.sjw),
    .tseg1   (seg_t1),
    .tseg2   (seg_t2),
    .sjw     (seg_sjw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      ph_q    <= 1'b0;
      done_q  <= 1'b0;
      clk_q   <= '0;
      presc_w <= '0;
      rate_w  <= '0;
      err_w   <= '0;
      unr_w   <= 1'b0;
      for (int i = 0; i < NPH; i++) begin
        cfg_q[i] <= '0;
        res_q[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start) begin
          clk_q    <= clk_hz;
          cfg_q[0] <= '{rate: nom_rate_target, tq: nom_tq_total,
                        sp: nom_sp_permille, sjw: nom_sjw_req};
          cfg_q[1] <= '{rate: dat_rate_target, tq: dat_tq_total,
                        sp: dat_sp_permille, sjw: dat_sjw_req};
          ph_q    <= 1'b0;
          step_q  <= '0;
          state_q <= S_LAUNCH;
        end
        S_LAUNCH: state_q <= S_WAIT;
        S_WAIT: if (div_valid) begin
          unique case (step_q)
            2'd0: begin
              if (div_q == '0) begin
                presc_w <= PRESC_W'(1);
                unr_w   <= 1'b1;
              end else if (div_q > PRESC_MAX) begin
                presc_w <= PRESC_W'(PRESC_MAX);
                unr_w   <= 1'b1;
              end else begin
                presc_w <= div_q[PRESC_W-1:0];
                unr_w   <= 1'b0;
              end
            end
            2'd1: rate_w <= (div_q > RATE_MAX) ? RATE_W'(RATE_MAX) : div_q[RATE_W-1:0];
            2'd2: err_w  <= err_neg ? -$signed(err_mag) : $signed(err_mag);
            default: begin
              res_q[ph_q] <= '{presc: presc_w, rate: rate_w, err: err_w,
                               tseg1: seg_t1, tseg2: seg_t2, sjw: seg_sjw,
                               unreach: unr_w};
            end
          endcase
          if (step_q == 2'd3) begin
            if (!ph_q) begin
              ph_q    <= 1'b1;
              step_q  <= '0;
              state_q <= S_LAUNCH;
            end else begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end
          end else begin
            step_q  <= step_q + 2'd1;
            state_q <= S_LAUNCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy = (state_q != S_IDLE);
  assign done = done_q;

  assign nom_presc       = res_q[0].presc;
  assign nom_rate_actual = res_q[0].rate;
  assign nom_err_bp      = res_q[0].err;
  assign nom_tseg1       = res_q[0].tseg1;
  assign nom_tseg2       = res_q[0].tseg2;
  assign nom_sjw         = res_q[0].sjw;
  assign nom_unreach     = res_q[0].unreach;
  assign dat_presc       = res_q[1].presc;
  assign dat_rate_actual = res_q[1].rate;
  assign dat_err_bp      = res_q[1].err;
  assign dat_tseg1       = res_q[1].tseg1;
  assign dat_tseg2       = res_q[1].tseg2;
  assign dat_sjw         = res_q[1].sjw;
  assign dat_unreach     = res_q[1].unreach;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_presc_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (nom_presc != '0 && dat_presc != '0));

  assert_sjw_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (nom_sjw <= nom_tseg2 && dat_sjw <= dat_tseg2));

  assert_seg_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_q[0].tq >= TQ_W'(3)) |->
      (({1'b0, nom_tseg1} + {1'b0, nom_tseg2} + 1'b1) == {1'b0, cfg_q[0].tq}));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

// File: tb/can_fd_timing_solver_bench.sv
`timescale 1ns/1ps
module can_fd_timing_solver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] clk_hz = '0;
  logic [31:0] nom_rate_target = '0, dat_rate_target = '0;
  logic [7:0]  nom_tq_total = '0, dat_tq_total = '0;
  logic [9:0]  nom_sp_permille = '0, dat_sp_permille = '0;
  logic [7:0]  nom_sjw_req = '0, dat_sjw_req = '0;
  logic        busy, done;
  logic [9:0]  nom_presc, dat_presc;
  logic [31:0] nom_rate_actual, dat_rate_actual;
  logic signed [31:0] nom_err_bp, dat_err_bp;
  logic [7:0]  nom_tseg1, nom_tseg2, nom_sjw, dat_tseg1, dat_tseg2, dat_sjw;
  logic        nom_unreach, dat_unreach;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  can_fd_timing_solver u_can_fd_timing_solver (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_hz(clk_hz),
    .nom_rate_target(nom_rate_target), .nom_tq_total(nom_tq_total),
    .nom_sp_permille(nom_sp_permille), .nom_sjw_req(nom_sjw_req),
    .dat_rate_target(dat_rate_target), .dat_tq_total(dat_tq_total),
    .dat_sp_permille(dat_sp_permille), .dat_sjw_req(dat_sjw_req),
    .busy(busy), .done(done),
    .nom_presc(nom_presc), .nom_rate_actual(nom_rate_actual), .nom_err_bp(nom_err_bp),
    .nom_tseg1(nom_tseg1), .nom_tseg2(nom_tseg2), .nom_sjw(nom_sjw), .nom_unreach(nom_unreach),
    .dat_presc(dat_presc), .dat_rate_actual(dat_rate_actual), .dat_err_bp(dat_err_bp),
    .dat_tseg1(dat_tseg1), .dat_tseg2(dat_tseg2), .dat_sjw(dat_sjw), .dat_unreach(dat_unreach)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int ck, input int nr, input int ntq, input int nsp, input int nsj,
                         input int dr, input int dtq, input int dsp, input int dsj);
    clk_hz = ck;
    nom_rate_target = nr; nom_tq_total = 8'(ntq); nom_sp_permille = 10'(nsp); nom_sjw_req = 8'(nsj);
    dat_rate_target = dr; dat_tq_total = 8'(dtq); dat_sp_permille = 10'(dsp); dat_sjw_req = 8'(dsj);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk); n++;
    end
    chk(req, "done seen", longint'(done), 1);
  endtask

  task automatic t_reset();
    chk("R10", "busy after reset", longint'(busy), 0);
    chk("R10", "done after reset", longint'(done), 0);
    chk("R10", "nom_presc after reset", longint'(nom_presc), 0);
    chk("R10", "dat_presc after reset", longint'(dat_presc), 0);
    chk("R10", "dat_rate after reset", longint'(dat_rate_actual), 0);
  endtask

  // 80 MHz: 20 TQ at 500k, 10 TQ at 2M
  task automatic t_exact();
    set_cfg(80_000_000, 500_000, 20, 800, 4, 2_000_000, 10, 700, 5);
    pulse_start();
    chk("R8", "busy while solving", longint'(busy), 1);
    wait_done("R8");
    chk("R8", "busy low at done", longint'(busy), 0);
    chk("R1", "nom presc", longint'(nom_presc), 8);
    chk("R3", "nom rate", longint'(nom_rate_actual), 500_000);
    chk("R4", "nom err", longint'(nom_err_bp), 0);
    chk("R5", "nom tseg1", longint'(nom_tseg1), 15);
    chk("R5", "nom tseg2", longint'(nom_tseg2), 4);
    chk("R7", "nom sjw", longint'(nom_sjw), 4);
    chk("R2", "nom unreach", longint'(nom_unreach), 0);
    chk("R1", "dat presc", longint'(dat_presc), 4);
    chk("R3", "dat rate", longint'(dat_rate_actual), 2_000_000);
    chk("R5", "dat tseg1", longint'(dat_tseg1), 6);
    chk("R5", "dat tseg2", longint'(dat_tseg2), 3);
    chk("R7", "dat sjw clamped", longint'(dat_sjw), 3);
    @(negedge clk);
    chk("R8", "done single cycle", longint'(done), 0);
  endtask

  // rounding up of the prescaler, negative and positive errors
  task automatic t_rounding();
    set_cfg(80_000_000, 300_000, 16, 800, 2, 0, 0, 0, 0);
    dat_rate_target = 350_000; dat_tq_total = 16; dat_sp_permille = 750; dat_sjw_req = 1;
    clk_hz = 40_000_000;
    // nominal at 40 MHz: 300k*16=4.8M, 40/4.8=8.33 -> 8; rate (40M+64)/128=312500
    pulse_start();
    wait_done("R1");
    chk("R1", "nom presc 8.33", longint'(nom_presc), 8);
    chk("R3", "nom rate", longint'(nom_rate_actual), 312_500);
    chk("R4", "nom err positive", longint'(nom_err_bp), 417);
    chk("R1", "dat presc 7.14", longint'(dat_presc), 7);
    chk("R3", "dat rate rounded", longint'(dat_rate_actual), 357_143);
    chk("R4", "dat err positive", longint'(dat_err_bp), 204);
    chk("R5", "dat tseg1", longint'(dat_tseg1), 11);
    chk("R5", "dat tseg2", longint'(dat_tseg2), 4);
    set_cfg(80_000_000, 300_000, 16, 800, 2, 2_000_000, 10, 700, 2);
    pulse_start();
    wait_done("R1");
    chk("R1", "nom presc 16.67 rounds up", longint'(nom_presc), 17);
    chk("R3", "nom rate", longint'(nom_rate_actual), 294_118);
    chk("R4", "nom err negative", longint'(nom_err_bp), -196);
  endtask

  task automatic t_unreach();
    // data 10M on 20 TQ at 80 MHz -> 0.4 -> 0 -> forced 1
    // nominal 1k on 20 TQ -> 4000 -> saturates at 1023
    set_cfg(80_000_000, 1_000, 20, 800, 3, 10_000_000, 20, 700, 3);
    pulse_start();
    wait_done("R2");
    chk("R2", "dat presc forced 1", longint'(dat_presc), 1);
    chk("R2", "dat unreach", longint'(dat_unreach), 1);
    chk("R3", "dat rate at presc 1", longint'(dat_rate_actual), 4_000_000);
    chk("R4", "dat err", longint'(dat_err_bp), -6000);
    chk("R2", "nom presc saturated", longint'(nom_presc), 1023);
    chk("R2", "nom unreach", longint'(nom_unreach), 1);
  endtask

  task automatic t_sp_clamp();
    set_cfg(80_000_000, 500_000, 10, 1000, 3, 2_000_000, 10, 0, 9);
    pulse_start();
    wait_done("R6");
    chk("R6", "nom tseg1 at 100%", longint'(nom_tseg1), 8);
    chk("R6", "nom tseg2 at 100%", longint'(nom_tseg2), 1);
    chk("R7", "nom sjw at tseg2 1", longint'(nom_sjw), 1);
    chk("R6", "dat tseg1 at 0%", longint'(dat_tseg1), 1);
    chk("R6", "dat tseg2 at 0%", longint'(dat_tseg2), 8);
    chk("R7", "dat sjw", longint'(dat_sjw), 8);
  endtask

  task automatic t_busy_start();
    set_cfg(80_000_000, 500_000, 20, 800, 4, 2_000_000, 10, 700, 5);
    pulse_start();
    repeat (30) @(negedge clk);
    set_cfg(40_000_000, 1_000_000, 8, 500, 1, 5_000_000, 8, 500, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "still busy after ignored start", longint'(busy), 1);
    wait_done("R9");
    chk("R9", "nom presc from first cfg", longint'(nom_presc), 8);
    chk("R9", "dat presc from first cfg", longint'(dat_presc), 4);
    chk("R9", "nom tseg1 from first cfg", longint'(nom_tseg1), 15);
    repeat (3) @(negedge clk);
    chk("R9", "no restart after done", longint'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_rounding();
    t_unreach();
    t_sp_clamp();
    t_busy_start();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule